// File: doc/BRIEF.md
# Confidentiality Offset Byte Mask Generator

This block sits beside the data path of an authenticated-encryption engine and tells it, byte by byte, what to do with each beat of a packet. A packet is split into two parts. The first part is a prefix whose length is programmable from 0 to 63 bytes; it stays in clear text but is still fed to the authentication function. The rest of the packet is encrypted. For every beat the block produces two per-byte masks: one for the authenticated-only prefix and one for the encrypted remainder.

The prefix length and two mode flags are taken from the start-of-packet beat and apply to the whole packet. The authentication-only flag turns every valid byte into an authenticated-only byte. The bypass flag clears both masks so the packet goes through untouched. A saturating position counter tracks where each beat lies relative to the packet start. The beat, its sideband signals and both masks leave the block through one register stage, so the masks line up with a one-cycle-delayed copy of the beat. The block serves one lane. The beat width is a parameter.

Top module: `conf_split_mask`

## Requirements
- R1: Every output is registered. `out_valid`, `out_sop`, `out_eop`, `out_keep` and `out_data` equal the matching inputs of the previous clock cycle, and the two masks belong to that same beat.
- R2: In cipher mode (neither flag set), the byte in lane i of the k-th valid beat of a packet (k = 0 on the start-of-packet beat) sits at position k*BEAT_BYTES + i. That byte is set in `out_aad_mask` when its position is below the offset and its keep bit is high. Otherwise it is set in `out_enc_mask` when its keep bit is high.
- R3: Any offset from 0 to 63 is honoured, including offsets that end in the middle of a beat. With 16-byte beats and offset 20, lanes 0..3 of the second beat are prefix bytes and lanes 4..15 are encrypted bytes.
- R4: An offset of 0 marks every kept byte for encryption, starting with the first beat.
- R5: With authentication-only set, `out_enc_mask` is zero on every beat of the packet and `out_aad_mask` equals the beat's keep.
- R6: With bypass set, both masks are zero on every beat of the packet. Bypass takes precedence over authentication-only.
- R7: A byte whose keep bit is low is in neither mask, and no byte is ever in both masks.
- R8: Offset, bypass and authentication-only are sampled only on the start-of-packet beat. Values presented on later beats of the same packet have no effect on the masks.
- R9: The position counter saturates at 64. Beats of an arbitrarily long packet past the prefix keep marking every kept byte for encryption.
- R10: A cycle with `in_valid` low gives `out_valid` low and both masks zero in the next cycle, and it does not advance the packet position.
- R11: While reset is held, `out_valid`, `out_sop`, `out_eop` and both masks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_keep | input | BEAT_BYTES | Per-byte enable of the beat |
| in_data | input | 8*BEAT_BYTES | Beat payload, lane i in bits 8i+7..8i |
| in_offset | input | 6 | Clear-text authenticated prefix length in bytes, sampled at start of packet |
| in_bypass | input | 1 | Pass packet untouched, sampled at start of packet |
| in_auth_only | input | 1 | Authenticate only, sampled at start of packet |
| out_valid | output | 1 | Delayed beat present |
| out_sop | output | 1 | Delayed start of packet |
| out_eop | output | 1 | Delayed end of packet |
| out_keep | output | BEAT_BYTES | Delayed byte enable |
| out_data | output | 8*BEAT_BYTES | Delayed beat payload |
| out_aad_mask | output | BEAT_BYTES | Bytes to authenticate without encrypting |
| out_enc_mask | output | BEAT_BYTES | Bytes to encrypt |

## Verification
The bench builds the block with its default 16-byte beat. At that width the 0..63 byte offset range spans up to four beats, so a prefix boundary can fall at a beat edge, in the middle of a beat, or in the last lane of the fourth beat. A ten-beat packet drives the position counter past its saturation point. Idle cycles inside a packet and altered sideband values on later beats show whether the position and the sampled packet settings stay frozen.

// File: rtl/csm_pkg.sv
package csm_pkg;

    // Offset range is fixed at 0..63 bytes
    localparam int OFS_W = 6;

    typedef enum logic [1:0] {
        MODE_CIPHER = 2'd0,
        MODE_AUTH   = 2'd1,
        MODE_PASS   = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e            mode;
        logic [OFS_W-1:0] offset;
    } pkt_ctx_t;

    // Bypass outranks authentication-only
    function automatic mode_e pick_mode(input logic byp, input logic ao);
        if (byp)
            return MODE_PASS;
        else if (ao)
            return MODE_AUTH;
        else
            return MODE_CIPHER;
    endfunction

endpackage

// File: rtl/csm_ctx_hold.sv
module csm_ctx_hold
    import csm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             sop,
    input  logic [OFS_W-1:0] offset,
    input  logic             byp,
    input  logic             ao,
    output pkt_ctx_t         ctx
);
    pkt_ctx_t held_q;
    pkt_ctx_t fresh;

    always_comb begin
        fresh.mode   = pick_mode(byp, ao);
        fresh.offset = offset;
    end

    // The start beat uses its own sideband; later beats use the held copy
    assign ctx = (valid && sop) ? fresh : held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q.mode   <= MODE_CIPHER;
            held_q.offset <= '0;
        end else if (valid && sop) begin
            held_q <= fresh;
        end
    end
endmodule

// File: rtl/csm_pos_track.sv
module csm_pos_track #(
    parameter int BEAT_BYTES = 16,
    parameter int LIMIT      = 64,
    parameter int POS_W      = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             sop,
    output logic [POS_W-1:0] base
);
    localparam logic [POS_W-1:0] STEP = POS_W'(BEAT_BYTES);
    localparam logic [POS_W-1:0] CAP  = POS_W'(LIMIT);

    logic [POS_W-1:0] cnt_q;
    logic [POS_W-1:0] next_pos;

    assign base     = sop ? '0 : cnt_q;
    assign next_pos = base + STEP;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (valid)
            cnt_q <= (next_pos >= CAP) ? CAP : next_pos;
    end
endmodule

// File: rtl/csm_lane_mask.sv
module csm_lane_mask
    import csm_pkg::*;
#(
    parameter int BEAT_BYTES = 16,
    parameter int POS_W      = 7
) (
    input  logic [POS_W-1:0]      base,
    input  pkt_ctx_t              ctx,
    input  logic                  valid,
    input  logic [BEAT_BYTES-1:0] keep,
    output logic [BEAT_BYTES-1:0] aad,
    output logic [BEAT_BYTES-1:0] enc
);
    logic [POS_W-1:0] limit;
    assign limit = POS_W'(ctx.offset);

    for (genvar i = 0; i < BEAT_BYTES; i++) begin : g_lane
        logic [POS_W-1:0] pos;
        logic             live;
        logic             in_prefix;

        assign pos       = base + POS_W'(i);
        assign live      = valid && keep[i];
        assign in_prefix = pos < limit;

        always_comb begin
            unique case (ctx.mode)
                MODE_PASS: begin
                    aad[i] = 1'b0;
                    enc[i] = 1'b0;
                end
                MODE_AUTH: begin
                    aad[i] = live;
                    enc[i] = 1'b0;
                end
                default: begin
                    aad[i] = live && in_prefix;
                    enc[i] = live && !in_prefix;
                end
            endcase
        end
    end
endmodule

// File: rtl/conf_split_mask.sv
module conf_split_mask
    import csm_pkg::*;
#(
    parameter int BEAT_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_sop,
    input  logic                    in_eop,
    input  logic [BEAT_BYTES-1:0]   in_keep,
    input  logic [8*BEAT_BYTES-1:0] in_data,
    input  logic [OFS_W-1:0]        in_offset,
    input  logic                    in_bypass,
    input  logic                    in_auth_only,
    output logic                    out_valid,
    output logic                    out_sop,
    output logic                    out_eop,
    output logic [BEAT_BYTES-1:0]   out_keep,
    output logic [8*BEAT_BYTES-1:0] out_data,
    output logic [BEAT_BYTES-1:0]   out_aad_mask,
    output logic [BEAT_BYTES-1:0]   out_enc_mask
);
    localparam int LIMIT = 1 << OFS_W;
    localparam int POS_W = $clog2(LIMIT + 2 * BEAT_BYTES);

    pkt_ctx_t              ctx;
    logic [POS_W-1:0]      base;
    logic [BEAT_BYTES-1:0] aad_d;
    logic [BEAT_BYTES-1:0] enc_d;

    csm_ctx_hold u_ctx (
        .clk    (clk),
        .rst    (rst),
        .valid  (in_valid),
        .sop    (in_sop),
        .offset (in_offset),
        .byp    (in_bypass),
        .ao     (in_auth_only),
        .ctx    (ctx)
    );

    csm_pos_track #(
        .BEAT_BYTES (BEAT_BYTES),
        .LIMIT      (LIMIT),
        .POS_W      (POS_W)
    ) u_pos (
        .clk   (clk),
        .rst   (rst),
        .valid (in_valid),
        .sop   (in_sop),
        .base  (base)
    );

    csm_lane_mask #(
        .BEAT_BYTES (BEAT_BYTES),
        .POS_W      (POS_W)
    ) u_mask (
        .base  (base),
        .ctx   (ctx),
        .valid (in_valid),
        .keep  (in_keep),
        .aad   (aad_d),
        .enc   (enc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_sop      <= 1'b0;
            out_eop      <= 1'b0;
            out_keep     <= '0;
            out_data     <= '0;
            out_aad_mask <= '0;
            out_enc_mask <= '0;
        end else begin
            out_valid    <= in_valid;
            out_sop      <= in_valid && in_sop;
            out_eop      <= in_valid && in_eop;
            out_keep     <= in_keep;
            out_data     <= in_data;
            out_aad_mask <= aad_d;
            out_enc_mask <= enc_d;
        end
    end
endmodule

// File: rtl/csm_checker.sv
module csm_checker #(
    parameter int BEAT_BYTES = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  in_sop,
    input logic [BEAT_BYTES-1:0] in_keep,
    input logic                  in_bypass,
    input logic                  in_auth_only,
    input logic [5:0]            in_offset,
    input logic                  out_valid,
    input logic [BEAT_BYTES-1:0] out_keep,
    input logic [BEAT_BYTES-1:0] out_aad_mask,
    input logic [BEAT_BYTES-1:0] out_enc_mask
);
    // R1: the beat appears one cycle later
    assert_beat_delay_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && out_keep == $past(in_keep)));

    // R4: zero offset in cipher mode encrypts the whole first beat
    assert_zero_offset_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && !in_bypass && !in_auth_only && in_offset == 6'd0)
        |=> (out_enc_mask == $past(in_keep) && out_aad_mask == '0));

    // R5: authentication-only start beat
    assert_auth_only_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && in_auth_only && !in_bypass)
        |=> (out_enc_mask == '0 && out_aad_mask == $past(in_keep)));

    // R6: bypass start beat clears both masks
    assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop && in_bypass)
        |=> (out_enc_mask == '0 && out_aad_mask == '0));

    // R7: masks are disjoint and confined to kept bytes
    assert_disjoint_R7: assert property (@(posedge clk) disable iff (rst)
        ((out_aad_mask & out_enc_mask) == '0));
    assert_within_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (((out_aad_mask | out_enc_mask) & ~out_keep) == '0));

    // R10: an idle input cycle gives an idle output cycle
    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && out_aad_mask == '0 && out_enc_mask == '0));
endmodule

bind conf_split_mask csm_checker #(.BEAT_BYTES(BEAT_BYTES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_sop       (in_sop),
    .in_keep      (in_keep),
    .in_bypass    (in_bypass),
    .in_auth_only (in_auth_only),
    .in_offset    (in_offset),
    .out_valid    (out_valid),
    .out_keep     (out_keep),
    .out_aad_mask (out_aad_mask),
    .out_enc_mask (out_enc_mask)
);

// File: tb/sim_conf_split_mask.sv
module sim_conf_split_mask;
    localparam int B = 16;

    logic           clk = 1'b0;
    logic           rst;
    logic           in_valid, in_sop, in_eop, in_bypass, in_auth_only;
    logic [B-1:0]   in_keep;
    logic [8*B-1:0] in_data;
    logic [5:0]     in_offset;
    logic           out_valid, out_sop, out_eop;
    logic [B-1:0]   out_keep, out_aad_mask, out_enc_mask;
    logic [8*B-1:0] out_data;

    int vectors = 0;
    int errors  = 0;

    always #5 clk = ~clk;

    conf_split_mask #(.BEAT_BYTES(B)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_keep(in_keep), .in_data(in_data), .in_offset(in_offset),
        .in_bypass(in_bypass), .in_auth_only(in_auth_only),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_keep(out_keep), .out_data(out_data),
        .out_aad_mask(out_aad_mask), .out_enc_mask(out_enc_mask)
    );

    task automatic chk(input string rq, input logic [8*B-1:0] act, input logic [8*B-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Expected masks from the requirements: md 0 cipher, 1 auth-only, 2 bypass
    task automatic expm(input int k, input logic [B-1:0] kp, input int off, input int md,
                        output logic [B-1:0] a, output logic [B-1:0] e);
        a = '0;
        e = '0;
        for (int i = 0; i < B; i++) begin
            if (kp[i] && md == 1) a[i] = 1'b1;
            else if (kp[i] && md == 0) begin
                if (k * B + i < off) a[i] = 1'b1;
                else                 e[i] = 1'b1;
            end
        end
    endtask

    task automatic idle_cycle(input string rq);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_keep = $urandom; in_offset = $urandom;
        @(posedge clk); #1;
        chk(rq, {127'b0, out_valid}, '0);
        chk(rq, {112'b0, out_aad_mask | out_enc_mask}, '0);
    endtask

    task automatic run_pkt(input string rq, input int n, input int off, input bit byp,
                           input bit ao, input logic [B-1:0] lastk,
                           input bit scramble, input bit gap);
        int md;
        logic [B-1:0] ea, ee;
        md = byp ? 2 : (ao ? 1 : 0);
        for (int k = 0; k < n; k++) begin
            logic [B-1:0]   kp;
            logic [8*B-1:0] d;
            kp = (k == n - 1) ? lastk : '1;
            d  = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
            in_valid = 1'b1; in_sop = (k == 0); in_eop = (k == n - 1);
            in_keep = kp; in_data = d;
            if (k == 0 || !scramble) begin
                in_offset = 6'(off); in_bypass = byp; in_auth_only = ao;
            end else begin
                in_offset = 6'(63 - off); in_bypass = ~byp; in_auth_only = ~ao;
            end
            @(posedge clk); #1;
            expm(k, kp, off, md, ea, ee);
            chk(rq, {112'b0, out_aad_mask}, {112'b0, ea});
            chk(rq, {112'b0, out_enc_mask}, {112'b0, ee});
            chk("R1 data", out_data, d);
            chk("R1 side", {125'b0, out_valid, out_sop, out_eop},
                {125'b0, 1'b1, 1'(k == 0), 1'(k == n - 1)});
            if (gap && k == 0) idle_cycle("R10 gap");
        end
        idle_cycle("R10 after packet");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0; in_keep = '1;
        in_data = '1; in_offset = 6'd0; in_bypass = 1'b0; in_auth_only = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11", {125'b0, out_valid, out_sop, out_eop}, '0);
        chk("R11", {96'b0, out_aad_mask, out_enc_mask}, '0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic t_zero_offset();  run_pkt("R4",  3, 0,  0, 0, '1, 0, 0); endtask
    task automatic t_mid_beat();     run_pkt("R3",  3, 20, 0, 0, '1, 0, 0); endtask
    task automatic t_beat_edge();    run_pkt("R2",  3, 32, 0, 0, '1, 0, 0); endtask
    task automatic t_max_offset();   run_pkt("R3",  5, 63, 0, 0, '1, 0, 0); endtask
    task automatic t_long_packet();  run_pkt("R9", 10, 63, 0, 0, 16'h00FF, 0, 0); endtask
    task automatic t_partial_keep(); run_pkt("R7",  2, 5,  0, 0, 16'h0F0F, 0, 0); endtask
    task automatic t_auth_only();    run_pkt("R5",  3, 20, 0, 1, 16'h3FFF, 0, 0); endtask
    task automatic t_bypass();       run_pkt("R6",  3, 20, 1, 0, '1, 0, 0); endtask
    task automatic t_bypass_wins();  run_pkt("R6",  2, 10, 1, 1, '1, 0, 0); endtask
    task automatic t_sampled_once(); run_pkt("R8",  4, 40, 0, 0, '1, 1, 0); endtask
    task automatic t_idle_gap();     run_pkt("R10", 3, 20, 0, 0, '1, 0, 1); endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_zero_offset();
        t_mid_beat();
        t_beat_edge();
        t_max_offset();
        t_long_packet();
        t_partial_keep();
        t_auth_only();
        t_bypass();
        t_bypass_wins();
        t_sampled_once();
        t_idle_gap();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule